// File: doc/BRIEF.md
# Programmable Asynchronous Serial Controller

This block is a host-attached serial line controller with independent transmit and receive paths. A host reaches five byte-wide registers over a small parallel port with select, write and read strobes. These registers are the control word, a read-only status word, the transmit holding register, the receive data register and a bit-rate divisor. The transmitter takes one byte from the holding register and sends it as an asynchronous frame. The frame has one start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one stop bit. The receiver rebuilds frames from the serial input, checks their parity and stop bit, and holds one received word for the host.

Each direction has its own 16x oversampling tick generator. The generator either divides the system clock by the divisor or follows rising edges on a dedicated external clock pin for that direction. A send-request output and a clear-to-send input provide hardware flow control. A single interrupt output combines a transmit-empty source and a receive-ready source, and each source is gated by its own enable bit.

Top module: `sercom_ctrl`

## Requirements
- R1: After reset, ser_out is 1 and send_req and int_req are 0, and the status word reads 8'h02 while send_ok is low. The control word (address 0) and divisor (address 4) read back the last value written, one cycle after the read strobe.
- R2: Control bits [1:0] = n give 5+n data bits. A frame is a 0 start bit, then the data bits least significant first, then the parity bit if enabled, then a 1 stop bit. Each bit lasts 16 ticks, and an internal tick comes every divisor+1 clock cycles.
- R3: Control bits [3:2] select parity: 2'b01 even (data plus parity bit hold an even count of ones), 2'b10 odd, and 2'b00 or 2'b11 none.
- R4: When control bit 4 is 1, each direction takes its ticks from rising edges of its own external clock pin (tx_ext_clk, rx_ext_clk) instead of the divisor.
- R5: A write to address 2 loads the holding register only when it is empty. A write while the register is full is discarded, and that byte is never sent.
- R6: send_req is high exactly while the holding register holds an unsent byte. A frame starts only while the synchronized send_ok is high, so the line stays idle (1) while send_ok is low.
- R7: The receiver accepts a start bit only if the line is still low half a bit after the falling edge. It samples each data bit at its centre, and address 3 returns the word with the unused upper bits at zero. A completed frame sets status bit 0.
- R8: Status bit 2 is 1 when parity is enabled and the received parity bit does not match the received data.
- R9: Status bit 3 is 1 when the last received stop bit was 0.
- R10: A read of address 3 clears status bit 0.
- R11: Status bit 4 (overrun) is set when a frame completes while status bit 0 is still set. A read of the status word clears it, and the receive register then holds the newer word.
- R12: int_req equals (control bit 6 AND receive ready) OR (control bit 5 AND holding register empty), registered one cycle.
- R13: Status layout: bit 0 receive ready, bit 1 holding empty, bit 2 parity error, bit 3 framing error, bit 4 overrun, bit 5 send_req, bit 6 synchronized send_ok, bit 7 int_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| ser_out | output | 1 | Serial transmit line, idle high |
| ser_in | input | 1 | Serial receive line, idle high |
| send_req | output | 1 | Request-to-send flow control output |
| send_ok | input | 1 | Clear-to-send flow control input |
| tx_ext_clk | input | 1 | External 16x clock for the transmitter |
| rx_ext_clk | input | 1 | External 16x clock for the receiver |
| int_req | output | 1 | Interrupt request |

## Verification
The bound checker watches, on every cycle, the rules that tie neighbouring events together. These rules are: the line is high whenever the transmitter is idle, a start bit never begins unless send_ok was seen, a load raises send_req, a data read drops the ready flag, a completion on an unread word raises overrun, and the interrupt follows its enables. Only the bench scenarios can show the frame contents themselves. That covers bit order, data length, parity polarity, bit duration under each tick source, the rejection of a short low glitch, and the discarding of a write into a full holding register. The bench shows these by decoding the line and by driving frames with deliberate parity and stop-bit faults.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

  localparam int BUS_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd4;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF  = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic      spare;
    logic      rx_ie;
    logic      tx_ie;
    logic      ext_clk;
    par_mode_e par;
    logic [1:0] len;
  } ctrl_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP
  } line_state_e;

  function automatic logic par_on(input par_mode_e m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] len,
                                   input par_mode_e m);
    logic [7:0] mask;
    mask = 8'hFF >> (2'd3 - len);
    return (^(d & mask)) ^ (m == PAR_ODD);
  endfunction

  function automatic logic [2:0] last_idx(input logic [1:0] len);
    return 3'd4 + {1'b0, len};
  endfunction

endpackage

// File: rtl/sercom_baud.sv
module sercom_baud #(
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             use_ext,
  input  logic [DIV_W-1:0] div,
  input  logic             ext_clk,
  output logic             tick
);

  logic [DIV_W-1:0]   cnt_q;
  logic [SYNC_STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sync_q <= '0;
      tick   <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk};
      if (use_ext) begin
        cnt_q <= '0;
        tick  <= sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
      end else if (cnt_q >= div) begin
        cnt_q <= '0;
        tick  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        tick  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
  import sercom_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       start,
  input  logic [7:0] data,
  input  logic [1:0] len,
  input  par_mode_e  par,
  output logic       line_o,
  output logic       idle
);

  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] OV_LAST = OW'(OVS - 1);

  line_state_e st_q;
  logic [OW-1:0] ov_q;
  logic [2:0]    idx_q;
  logic [7:0]    sh_q;
  logic          pb_q;

  assign idle = (st_q == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= S_IDLE;
      line_o <= 1'b1;
      ov_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pb_q   <= 1'b0;
    end else if (st_q == S_IDLE) begin
      line_o <= 1'b1;
      if (start) begin
        st_q   <= S_START;
        line_o <= 1'b0;
        sh_q   <= data;
        pb_q   <= par_bit(data, len, par);
        ov_q   <= '0;
        idx_q  <= '0;
      end
    end else if (tick) begin
      if (ov_q != OV_LAST) begin
        ov_q <= ov_q + 1'b1;
      end else begin
        ov_q <= '0;
        case (st_q)
          S_START: begin
            st_q   <= S_DATA;
            line_o <= sh_q[0];
          end
          S_DATA: begin
            if (idx_q == last_idx(len)) begin
              if (par_on(par)) begin
                st_q   <= S_PAR;
                line_o <= pb_q;
              end else begin
                st_q   <= S_STOP;
                line_o <= 1'b1;
              end
            end else begin
              idx_q  <= idx_q + 1'b1;
              line_o <= sh_q[idx_q + 3'd1];
            end
          end
          S_PAR: begin
            st_q   <= S_STOP;
            line_o <= 1'b1;
          end
          default: begin
            st_q   <= S_IDLE;
            line_o <= 1'b1;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line_i,
  input  logic [1:0] len,
  input  par_mode_e  par,
  output logic       done,
  output logic [7:0] word,
  output logic       perr,
  output logic       ferr
);

  localparam int OW = $clog2(OVS);
  localparam logic [OW-1:0] OV_LAST = OW'(OVS - 1);
  localparam logic [OW-1:0] OV_HALF = OW'(OVS / 2 - 1);

  logic [1:0]    sy_q;
  logic          rxs;
  line_state_e   st_q;
  logic [OW-1:0] ov_q;
  logic [2:0]    idx_q;
  logic [7:0]    sh_q;
  logic          pbit_q;

  assign rxs = sy_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sy_q   <= 2'b11;
      st_q   <= S_IDLE;
      ov_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      pbit_q <= 1'b0;
      done   <= 1'b0;
      word   <= '0;
      perr   <= 1'b0;
      ferr   <= 1'b0;
    end else begin
      sy_q <= {sy_q[0], line_i};
      done <= 1'b0;
      if (tick) begin
        case (st_q)
          S_IDLE: begin
            if (!rxs) begin
              st_q <= S_START;
              ov_q <= '0;
            end
          end
          S_START: begin
            if (ov_q == OV_HALF) begin
              ov_q <= '0;
              if (!rxs) begin
                st_q  <= S_DATA;
                idx_q <= '0;
                sh_q  <= '0;
              end else begin
                st_q <= S_IDLE;
              end
            end else begin
              ov_q <= ov_q + 1'b1;
            end
          end
          S_DATA: begin
            if (ov_q == OV_LAST) begin
              ov_q        <= '0;
              sh_q[idx_q] <= rxs;
              if (idx_q == last_idx(len)) begin
                st_q <= par_on(par) ? S_PAR : S_STOP;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end else begin
              ov_q <= ov_q + 1'b1;
            end
          end
          S_PAR: begin
            if (ov_q == OV_LAST) begin
              ov_q   <= '0;
              pbit_q <= rxs;
              st_q   <= S_STOP;
            end else begin
              ov_q <= ov_q + 1'b1;
            end
          end
          default: begin
            if (ov_q == OV_LAST) begin
              ov_q <= '0;
              st_q <= S_IDLE;
              done <= 1'b1;
              word <= sh_q;
              ferr <= ~rxs;
              perr <= par_on(par) && (pbit_q != par_bit(sh_q, len, par));
            end else begin
              ov_q <= ov_q + 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/sercom_ctrl.sv
module sercom_ctrl
  import sercom_pkg::*;
#(
  parameter int             DIV_W   = 8,
  parameter int             OVS     = 16,
  parameter logic [DIV_W-1:0] DIV_RST = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              ser_out,
  input  logic              ser_in,
  output logic              send_req,
  input  logic              send_ok,
  input  logic              tx_ext_clk,
  input  logic              rx_ext_clk,
  output logic              int_req
);

  localparam int NDIR = 2;

  ctrl_t            ctrl_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       thr_q;
  logic             thr_full_q;
  logic             rx_rdy_q;
  logic             ovr_q;
  logic             int_q;
  logic [1:0]       ok_sync_q;
  logic             ok_s;

  logic wr_en, rd_en, wr_txd, rd_rxd, rd_stat;
  logic tx_idle, tx_start;
  logic rx_done, rx_perr, rx_ferr;
  logic [7:0] rx_word;
  logic [NDIR-1:0] ext_pins, ticks;
  logic [BUS_W-1:0] status;

  assign wr_en   = bus_sel & bus_wr;
  assign rd_en   = bus_sel & bus_rd;
  assign wr_txd  = wr_en & (bus_addr == A_TXD);
  assign rd_rxd  = rd_en & (bus_addr == A_RXD);
  assign rd_stat = rd_en & (bus_addr == A_STAT);
  assign ok_s    = ok_sync_q[1];
  assign tx_start = thr_full_q & ok_s & tx_idle;
  assign ext_pins = {rx_ext_clk, tx_ext_clk};

  for (genvar g = 0; g < NDIR; g++) begin : g_clkgen
    sercom_baud #(.DIV_W(DIV_W), .SYNC_STAGES(2)) u_gen (
      .clk     (clk),
      .rst     (rst),
      .use_ext (ctrl_q.ext_clk),
      .div     (div_q),
      .ext_clk (ext_pins[g]),
      .tick    (ticks[g])
    );
  end

  sercom_tx #(.OVS(OVS)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .tick   (ticks[0]),
    .start  (tx_start),
    .data   (thr_q),
    .len    (ctrl_q.len),
    .par    (ctrl_q.par),
    .line_o (ser_out),
    .idle   (tx_idle)
  );

  sercom_rx #(.OVS(OVS)) u_rx (
    .clk    (clk),
    .rst    (rst),
    .tick   (ticks[1]),
    .line_i (ser_in),
    .len    (ctrl_q.len),
    .par    (ctrl_q.par),
    .done   (rx_done),
    .word   (rx_word),
    .perr   (rx_perr),
    .ferr   (rx_ferr)
  );

  assign status = {int_q, ok_s, thr_full_q, ovr_q, rx_ferr, rx_perr, ~thr_full_q, rx_rdy_q};
  assign send_req = thr_full_q;
  assign int_req  = int_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      div_q      <= DIV_RST;
      thr_q      <= '0;
      thr_full_q <= 1'b0;
      rx_rdy_q   <= 1'b0;
      ovr_q      <= 1'b0;
      int_q      <= 1'b0;
      ok_sync_q  <= '0;
      bus_rdata  <= '0;
    end else begin
      ok_sync_q <= {ok_sync_q[0], send_ok};

      if (wr_en && bus_addr == A_CTRL) ctrl_q <= ctrl_t'(bus_wdata);
      if (wr_en && bus_addr == A_DIV)  div_q  <= bus_wdata[DIV_W-1:0];

      if (tx_start) thr_full_q <= 1'b0;
      if (wr_txd && !thr_full_q) begin
        thr_q      <= bus_wdata;
        thr_full_q <= 1'b1;
      end

      if (rd_stat) ovr_q <= 1'b0;
      if (rx_done) begin
        rx_rdy_q <= 1'b1;
        if (rx_rdy_q && !rd_rxd) ovr_q <= 1'b1;
      end else if (rd_rxd) begin
        rx_rdy_q <= 1'b0;
      end

      int_q <= (ctrl_q.rx_ie & rx_rdy_q) | (ctrl_q.tx_ie & ~thr_full_q);

      if (rd_en) begin
        case (bus_addr)
          A_CTRL:  bus_rdata <= ctrl_q;
          A_STAT:  bus_rdata <= status;
          A_TXD:   bus_rdata <= thr_q;
          A_RXD:   bus_rdata <= rx_word;
          A_DIV:   bus_rdata <= BUS_W'(div_q);
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/sercom_ctrl_chk.sv
module sercom_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic ser_out,
  input logic tx_idle,
  input logic ok_s,
  input logic wr_txd,
  input logic send_req,
  input logic rd_rxd,
  input logic rx_done,
  input logic rx_rdy,
  input logic ovr,
  input logic ie_rx,
  input logic ie_tx,
  input logic int_req
);

  p_idle_mark_r2: assert property (@(posedge clk) disable iff (rst)
    tx_idle |-> ser_out);

  p_start_gated_r6: assert property (@(posedge clk) disable iff (rst)
    ($fell(ser_out) && $past(tx_idle)) |-> $past(ok_s));

  p_req_on_load_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_txd && !send_req) |=> send_req);

  p_ready_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_rxd && !rx_done) |=> !rx_rdy);

  p_overrun_set_r11: assert property (@(posedge clk) disable iff (rst)
    (rx_done && rx_rdy && !rd_rxd) |=> ovr);

  p_irq_masked_r12: assert property (@(posedge clk) disable iff (rst)
    (!$past(ie_rx) && !$past(ie_tx)) |-> !int_req);

  p_irq_ready_r12: assert property (@(posedge clk) disable iff (rst)
    (ie_rx && rx_rdy) |=> int_req);

endmodule

bind sercom_ctrl sercom_ctrl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ser_out  (ser_out),
  .tx_idle  (tx_idle),
  .ok_s     (ok_s),
  .wr_txd   (wr_txd),
  .send_req (send_req),
  .rd_rxd   (rd_rxd),
  .rx_done  (rx_done),
  .rx_rdy   (rx_rdy_q),
  .ovr      (ovr_q),
  .ie_rx    (ctrl_q.rx_ie),
  .ie_tx    (ctrl_q.tx_ie),
  .int_req  (int_req)
);

// File: tb/sercom_ctrl_tb.sv
`timescale 1ns/1ps
module sercom_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       ser_out, send_req, int_req;
  logic       ser_in = 1'b1;
  logic       send_ok = 1'b0;
  logic       ext_clk = 1'b0;

  int checks = 0;
  int errors = 0;
  int bit_cyc = 64;
  logic [1:0] cfg_len = 2'd3;
  logic [1:0] cfg_par = 2'b00;
  int tx_seen = 0;
  logic [7:0] tx_q[$];
  logic [9:0] rx_q[$];

  always #10 clk = ~clk;

  always begin
    repeat (4) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  sercom_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_out(ser_out), .ser_in(ser_in), .send_req(send_req), .send_ok(send_ok),
    .tx_ext_clk(ext_clk), .rx_ext_clk(ext_clk), .int_req(int_req)
  );

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_par(input logic [7:0] d, input int nb, input logic [1:0] pm);
    int ones;
    ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    return (pm == 2'b10) ? ~ones[0] : ones[0];
  endfunction

  function automatic logic [7:0] mask_of(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  // control: [1:0] length code, [3:2] parity, [4] external clock, [5] tx irq en, [6] rx irq en
  task automatic set_cfg(input logic [1:0] len, input logic [1:0] par, input logic ext,
                         input logic txie, input logic rxie, input logic [7:0] dv);
    bus_write(3'd4, dv);
    bus_write(3'd0, {1'b0, rxie, txie, ext, par, len});
    cfg_len = len;
    cfg_par = par;
    bit_cyc = ext ? 16 * 8 : 16 * (int'(dv) + 1);
  endtask

  task automatic tx_send(input logic [7:0] d);
    tx_q.push_back(d);
    bus_write(3'd2, d);
  endtask

  task automatic wait_tx(input int n);
    while (tx_seen < n) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  // line monitor: decodes each frame on ser_out and compares it with the queue
  initial begin
    logic [7:0] exp, got;
    int nb;
    forever begin
      @(negedge ser_out);
      repeat (bit_cyc / 2) @(negedge clk);
      nb = 5 + int'(cfg_len);
      check(ser_out == 1'b0, "R2 start bit", 32'(ser_out), 32'd0);
      got = '0;
      for (int i = 0; i < nb; i++) begin
        repeat (bit_cyc) @(negedge clk);
        got[i] = ser_out;
      end
      if (tx_q.size() == 0) begin
        check(1'b0, "R5 unexpected frame", 32'(got), 32'hFFFF);
        exp = '0;
      end else begin
        exp = tx_q.pop_front() & mask_of(cfg_len);
      end
      check(got == exp, "R2 data bits lsb first", 32'(got), 32'(exp));
      if (cfg_par == 2'b01 || cfg_par == 2'b10) begin
        repeat (bit_cyc) @(negedge clk);
        check(ser_out == exp_par(exp, nb, cfg_par), "R3 parity bit", 32'(ser_out),
              32'(exp_par(exp, nb, cfg_par)));
      end
      repeat (bit_cyc) @(negedge clk);
      check(ser_out == 1'b1, "R2 stop bit", 32'(ser_out), 32'd1);
      tx_seen++;
    end
  end

  task automatic rx_drive(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    int nb;
    logic pb;
    logic [7:0] m;
    nb = 5 + int'(cfg_len);
    m  = d & mask_of(cfg_len);
    pb = exp_par(m, nb, cfg_par);
    rx_q.push_back({bad_par, bad_stop, m});
    @(negedge clk);
    ser_in = 1'b0;
    repeat (bit_cyc) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      ser_in = d[i];
      repeat (bit_cyc) @(negedge clk);
    end
    if (cfg_par == 2'b01 || cfg_par == 2'b10) begin
      ser_in = pb ^ bad_par;
      repeat (bit_cyc) @(negedge clk);
    end
    ser_in = ~bad_stop;
    repeat (bit_cyc) @(negedge clk);
    ser_in = 1'b1;
    repeat (bit_cyc) @(negedge clk);
  endtask

  // status: [0] rx ready [1] tx empty [2] parity err [3] framing err [4] overrun
  task automatic rx_collect();
    logic [7:0] s, d;
    logic [9:0] e;
    bus_read(3'd1, s);
    e = rx_q.pop_front();
    check(s[0] == 1'b1, "R7 ready set", 32'(s), 32'h1);
    check(s[2] == e[9], "R8 parity error flag", 32'(s[2]), 32'(e[9]));
    check(s[3] == e[8], "R9 framing error flag", 32'(s[3]), 32'(e[8]));
    bus_read(3'd3, d);
    check(d == e[7:0], "R7 received word", 32'(d), 32'(e[7:0]));
    bus_read(3'd1, s);
    check(s[0] == 1'b0, "R10 ready cleared by read", 32'(s[0]), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    check(ser_out == 1'b1 && send_req == 1'b0 && int_req == 1'b0, "R1 reset outputs",
          {29'd0, ser_out, send_req, int_req}, 32'h4);
    bus_read(3'd1, r);
    check(r == 8'h02, "R1 R13 reset status", 32'(r), 32'h02);

    set_cfg(2'd3, 2'b01, 1'b0, 1'b0, 1'b0, 8'd3);
    bus_read(3'd0, r);
    check(r == 8'h07, "R1 control readback", 32'(r), 32'h07);
    bus_read(3'd4, r);
    check(r == 8'd3, "R1 divisor readback", 32'(r), 32'd3);

    // flow control and full holding register
    tx_send(8'hA5);
    repeat (4) @(negedge clk);
    check(send_req == 1'b1, "R6 send_req while full", 32'(send_req), 32'd1);
    bus_read(3'd1, r);
    check(r[1] == 1'b0 && r[5] == 1'b1, "R13 status full", 32'(r), 32'h20);
    bus_write(3'd2, 8'h3C);
    repeat (200) @(negedge clk);
    check(ser_out == 1'b1 && tx_seen == 0, "R6 held idle without send_ok", 32'(ser_out), 32'd1);
    send_ok = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(3'd1, r);
    check(r[6] == 1'b1, "R13 send_ok in status", 32'(r), 32'h40);
    wait_tx(1);
    check(send_req == 1'b0, "R6 send_req drops", 32'(send_req), 32'd0);
    repeat (12 * bit_cyc) @(negedge clk);
    check(tx_seen == 1 && ser_out == 1'b1, "R5 write into full register discarded",
          32'(tx_seen), 32'd1);

    // odd parity, seven data bits, two frames
    set_cfg(2'd2, 2'b10, 1'b0, 1'b0, 1'b0, 8'd3);
    tx_send(8'hD3);
    while (send_req) @(negedge clk);
    tx_send(8'h0F);
    wait_tx(3);

    // five data bits, no parity
    set_cfg(2'd0, 2'b11, 1'b0, 1'b0, 1'b0, 8'd3);
    tx_send(8'hFF);
    while (send_req) @(negedge clk);
    tx_send(8'h12);
    wait_tx(5);

    // R4 external clock on transmit
    set_cfg(2'd3, 2'b00, 1'b1, 1'b0, 1'b0, 8'd3);
    tx_send(8'h81);
    wait_tx(6);
    check(tx_seen == 6, "R4 external clock transmit frame count", 32'(tx_seen), 32'd6);

    // R4 external clock on receive
    rx_drive(8'hC3, 1'b0, 1'b0);
    rx_collect();

    // receive paths
    set_cfg(2'd3, 2'b01, 1'b0, 1'b0, 1'b0, 8'd3);
    rx_drive(8'h5A, 1'b0, 1'b0);
    rx_collect();
    set_cfg(2'd2, 2'b10, 1'b0, 1'b0, 1'b0, 8'd3);
    rx_drive(8'hB3, 1'b0, 1'b0);
    rx_collect();
    rx_drive(8'h2C, 1'b1, 1'b0);
    rx_collect();
    set_cfg(2'd0, 2'b00, 1'b0, 1'b0, 1'b0, 8'd3);
    rx_drive(8'hF5, 1'b0, 1'b0);
    rx_collect();
    rx_drive(8'h0A, 1'b0, 1'b1);
    rx_collect();

    // R7 short glitch is not a start bit
    set_cfg(2'd3, 2'b00, 1'b0, 1'b0, 1'b0, 8'd3);
    @(negedge clk);
    ser_in = 1'b0;
    repeat (12) @(negedge clk);
    ser_in = 1'b1;
    repeat (3 * bit_cyc) @(negedge clk);
    bus_read(3'd1, r);
    check(r[0] == 1'b0, "R7 glitch rejected", 32'(r[0]), 32'd0);

    // R11 overrun
    rx_drive(8'h11, 1'b0, 1'b0);
    rx_drive(8'h22, 1'b0, 1'b0);
    void'(rx_q.pop_front());
    void'(rx_q.pop_front());
    bus_read(3'd1, r);
    check(r[4] == 1'b1 && r[0] == 1'b1, "R11 overrun flag", 32'(r), 32'h11);
    bus_read(3'd3, r);
    check(r == 8'h22, "R11 newer word kept", 32'(r), 32'h22);
    bus_read(3'd1, r);
    check(r[4] == 1'b0, "R11 overrun cleared by status read", 32'(r[4]), 32'd0);

    // R12 interrupt
    set_cfg(2'd3, 2'b00, 1'b0, 1'b0, 1'b1, 8'd3);
    repeat (3) @(negedge clk);
    check(int_req == 1'b0, "R12 no source active", 32'(int_req), 32'd0);
    rx_drive(8'h6E, 1'b0, 1'b0);
    check(int_req == 1'b1, "R12 receive ready interrupt", 32'(int_req), 32'd1);
    bus_read(3'd1, r);
    check(r[7] == 1'b1, "R13 interrupt in status", 32'(r), 32'h80);
    bus_read(3'd3, r);
    void'(rx_q.pop_front());
    check(r == 8'h6E, "R7 word under interrupt", 32'(r), 32'h6E);
    repeat (2) @(negedge clk);
    check(int_req == 1'b0, "R12 interrupt drops after read", 32'(int_req), 32'd0);
    set_cfg(2'd3, 2'b00, 1'b0, 1'b1, 1'b1, 8'd3);
    repeat (2) @(negedge clk);
    check(int_req == 1'b1, "R12 transmit empty interrupt", 32'(int_req), 32'd1);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule